// File: doc/BRIEF.md
# Synchronous Output Clock Stop Gating

This block sits between the dividers of a clock generator and its output pins. It gates two families of generated clocks. The first family is a set of single-ended bus clocks. The second is a set of differential processor clock pairs. Each family answers to its own active-low stop request, and each output has its own enable bit and stoppable bit from configuration. All source clocks are modelled as levels produced in one fast system clock domain (`clk`). Each gated output is a registered copy of its source level, delayed by one `clk` cycle.

A stop request is first taken through a synchronizer. The block then changes its gating decision only at instants where the change cannot shorten a pulse. A bus clock can change state only while its source is low, so when it halts it rests low. A processor pair can change state only on a rising edge of its source, so when it halts its true output stays high and its complement output is released. When the request is withdrawn, each output picks up again in the phase of its undisturbed source.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, every bus clock output is 0 and every processor pair is parked (`cpu_t`=1, `cpu_c`=0, `cpu_c_drv`=0).
- R2: Each stop input passes through SYNC_STAGES (default 2) flip-flops on `clk`. A level sampled at edge k is used in the gating decision at edge k+SYNC_STAGES.
- R3: A bus clock whose stoppable bit is 1 stops when its synchronized stop is active. It stops on its next high-to-low transition, stays low from then on, and never has a high phase cut short.
- R4: A bus clock whose stoppable bit is 0 keeps toggling while its stop request is active.
- R5: A stopped or disabled bus clock restarts only on a rising edge of its source. Every high pulse lasts exactly as long as the source high phase, and the output is always the source delayed by one `clk` cycle or 0.
- R6: A bus clock whose enable bit is 0 stays low. A change of the enable bit takes effect during a low phase of the source.
- R7: The synchronized processor stop is sampled on CPU_SAMPLE_EDGES (default 2) rising edges of `cpu_src`. Stoppable pairs park on the rising edge that follows the last sample.
- R8: A parked pair shows `cpu_t`=1, `cpu_c`=0 and `cpu_c_drv`=0. Parking and release happen only on a rising source edge, so `cpu_t` does not glitch.
- R9: A pair whose stoppable bit is 0 keeps running while the processor stop is active.
- R10: A pair whose enable bit is 0 parks at the same levels as a stopped pair.
- R11: A running pair drives `cpu_c_drv`=1, with `cpu_t` equal to `cpu_src` delayed by one cycle and `cpu_c` its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that all source levels are generated in |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stop_n | input | 1 | Active-low stop request for bus clocks, asynchronous |
| cpu_stop_n | input | 1 | Active-low stop request for processor pairs, asynchronous |
| bus_src | input | N_BUS | Divided bus source clock levels |
| bus_en | input | N_BUS | Per-bus-clock enable (1 = enabled) |
| bus_stoppable | input | N_BUS | Per-bus-clock stoppable bit (0 = free-running) |
| cpu_src | input | 1 | Divided processor source clock level |
| cpu_en | input | N_CPU | Per-pair enable (1 = enabled) |
| cpu_stoppable | input | N_CPU | Per-pair stoppable bit (0 = free-running) |
| bus_clk | output | N_BUS | Gated bus clocks |
| cpu_t | output | N_CPU | True side of each processor pair |
| cpu_c | output | N_CPU | Complement side of each processor pair |
| cpu_c_drv | output | N_CPU | Complement output driver enable (0 = not driven) |

## Verification
The embedded properties assume the following:
- Every source level is produced synchronously to `clk`.
- Each high and low phase of a source lasts at least one `clk` cycle.
- The stop inputs may change at any time, but the enable and stoppable bits are sampled like any other synchronous input.

The stimulus keeps to these assumptions. It derives the bus and processor sources from a single bench counter, with eight-cycle and four-cycle periods and staggered bus phases. It changes the stop levels and the masks only on falling `clk` edges. The stop pulses are pseudo-random and run from one cycle to many periods long, so they hit every phase of both source families.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

   typedef enum logic {
      GATE_HALT = 1'b0,
      GATE_RUN  = 1'b1
   } gate_state_e;

   // gating decision shared by both output families
   function automatic gate_state_e next_gate(input logic en,
                                             input logic stoppable,
                                             input logic stop_act);
      return (en && !(stoppable && stop_act)) ? GATE_RUN : GATE_HALT;
   endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/clkstop_cpu_sample.sv
module clkstop_cpu_sample #(
   parameter int EDGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic stop_act,
   output logic req
);
   logic             src_q;
   logic [EDGES-1:0] pipe;
   logic             rise;

   assign rise = src && !src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         pipe  <= '0;
      end else begin
         src_q <= src;
         if (rise) pipe <= {pipe[EDGES-2:0], stop_act};
      end
   end

   assign req = pipe[EDGES-1];

   // R7: the sampled request only moves on a rising source edge
   assert_sample_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(req) |-> $rose(src_q));
endmodule

// File: rtl/clkstop_bus_lane.sv
module clkstop_bus_lane
   import clkstop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic en,
   input  logic stoppable,
   input  logic stop_act,
   output logic clk_out
);
   logic        src_q;
   gate_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         st    <= GATE_HALT;
      end else begin
         src_q <= src;
         // decisions move only while the source is low
         if (!src) st <= next_gate(en, stoppable, stop_act);
      end
   end

   assign clk_out = src_q && (st == GATE_RUN);

   assert_bus_no_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_out) |-> $fell(src_q));

   assert_bus_clean_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out) |-> $rose(src_q));

   assert_bus_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == GATE_RUN && !stoppable && en) |=> (st == GATE_RUN));

   assert_bus_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !src) |=> !clk_out);
endmodule

// File: rtl/clkstop_cpu_lane.sv
module clkstop_cpu_lane
   import clkstop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic en,
   input  logic stoppable,
   input  logic req,
   output logic out_t,
   output logic out_c,
   output logic c_drv
);
   logic        src_q;
   gate_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         st    <= GATE_HALT;
      end else begin
         src_q <= src;
         // decisions move only on a rising source edge
         if (src && !src_q) st <= next_gate(en, stoppable, req);
      end
   end

   assign c_drv = (st == GATE_RUN);
   assign out_t = c_drv ? src_q : 1'b1;
   assign out_c = c_drv ? !src_q : 1'b0;

   assert_cpu_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !c_drv |-> (out_t && !out_c));

   assert_cpu_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(c_drv) |-> out_t);

   assert_cpu_comp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      c_drv |-> (out_c != out_t));

   assert_cpu_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (c_drv && !stoppable && en) |=> c_drv);
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
   parameter int N_BUS            = 10,
   parameter int N_CPU            = 3,
   parameter int SYNC_STAGES      = 2,
   parameter int CPU_SAMPLE_EDGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_stop_n,
   input  logic             cpu_stop_n,
   input  logic [N_BUS-1:0] bus_src,
   input  logic [N_BUS-1:0] bus_en,
   input  logic [N_BUS-1:0] bus_stoppable,
   input  logic             cpu_src,
   input  logic [N_CPU-1:0] cpu_en,
   input  logic [N_CPU-1:0] cpu_stoppable,
   output logic [N_BUS-1:0] bus_clk,
   output logic [N_CPU-1:0] cpu_t,
   output logic [N_CPU-1:0] cpu_c,
   output logic [N_CPU-1:0] cpu_c_drv
);
   if (N_BUS < 1) begin : g_bad_bus
      $error("clkstop_gate: N_BUS must be at least 1");
   end
   if (N_CPU < 1) begin : g_bad_cpu
      $error("clkstop_gate: N_CPU must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("clkstop_gate: SYNC_STAGES must be at least 2");
   end
   if (CPU_SAMPLE_EDGES < 2) begin : g_bad_edges
      $error("clkstop_gate: CPU_SAMPLE_EDGES must be at least 2");
   end

   logic bus_stop_s, cpu_stop_s;
   logic bus_act, cpu_act, cpu_req;

   clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .din(bus_stop_n), .dout(bus_stop_s));

   clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cpu_sync (
      .clk(clk), .rst_n(rst_n), .din(cpu_stop_n), .dout(cpu_stop_s));

   assign bus_act = !bus_stop_s;
   assign cpu_act = !cpu_stop_s;

   clkstop_cpu_sample #(.EDGES(CPU_SAMPLE_EDGES)) u_cpu_sample (
      .clk(clk), .rst_n(rst_n), .src(cpu_src), .stop_act(cpu_act), .req(cpu_req));

   for (genvar i = 0; i < N_BUS; i++) begin : g_bus
      clkstop_bus_lane u_lane (
         .clk(clk), .rst_n(rst_n), .src(bus_src[i]), .en(bus_en[i]),
         .stoppable(bus_stoppable[i]), .stop_act(bus_act), .clk_out(bus_clk[i]));
   end

   for (genvar j = 0; j < N_CPU; j++) begin : g_cpu
      clkstop_cpu_lane u_lane (
         .clk(clk), .rst_n(rst_n), .src(cpu_src), .en(cpu_en[j]),
         .stoppable(cpu_stoppable[j]), .req(cpu_req),
         .out_t(cpu_t[j]), .out_c(cpu_c[j]), .c_drv(cpu_c_drv[j]));
   end

   // R1: reset leaves every output in its rest state
   always_comb begin
      if (!rst_n) begin
         assert_reset_rest_R1: assert (bus_clk == '0 && cpu_t == '1 &&
                                       cpu_c == '0 && cpu_c_drv == '0);
      end
   end
endmodule

// File: tb/clkstop_gate_bench.sv
module clkstop_gate_bench;
   localparam int NB = 10;
   localparam int NC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_stop_n = 1'b1, cpu_stop_n = 1'b1;
   logic [NB-1:0] bus_src = '0, bus_en = '1, bus_stoppable = 10'b1111111000;
   logic cpu_src = 1'b0;
   logic [NC-1:0] cpu_en = '1, cpu_stoppable = 3'b110;
   logic [NB-1:0] bus_clk;
   logic [NC-1:0] cpu_t, cpu_c, cpu_c_drv;

   int checks = 0, errors = 0, cyc = 0, cnt = 0;
   bit done = 0;

   clkstop_gate #(.N_BUS(NB), .N_CPU(NC)) u_clkstop_gate (
      .clk(clk), .rst_n(rst_n), .bus_stop_n(bus_stop_n), .cpu_stop_n(cpu_stop_n),
      .bus_src(bus_src), .bus_en(bus_en), .bus_stoppable(bus_stoppable),
      .cpu_src(cpu_src), .cpu_en(cpu_en), .cpu_stoppable(cpu_stoppable),
      .bus_clk(bus_clk), .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_c_drv(cpu_c_drv));

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // sources: bus period 8 with staggered phase, processor period 4
   always @(negedge clk) begin
      cnt++;
      for (int i = 0; i < NB; i++) bus_src[i] <= ((cnt + i) % 8) < 4;
      cpu_src <= (cnt % 4) < 2;
   end

   // behavioural reference model
   bit bh[$], ch[$], cp[$];
   bit [NB-1:0] m_bsq, m_brun;
   bit m_csq;
   bit [NC-1:0] m_crun;
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         bh = '{1, 1}; ch = '{1, 1}; cp = '{0, 0};
         m_bsq = '0; m_brun = '0; m_csq = 0; m_crun = '0;
      end else begin
         bit bact, cact, rise, req;
         bact = !bh[0]; void'(bh.pop_front()); bh.push_back(bus_stop_n);
         cact = !ch[0]; void'(ch.pop_front()); ch.push_back(cpu_stop_n);
         for (int i = 0; i < NB; i++) begin
            if (!bus_src[i]) m_brun[i] = bus_en[i] && !(bus_stoppable[i] && bact);
            m_bsq[i] = bus_src[i];
         end
         rise = cpu_src && !m_csq;
         req  = cp[0];
         if (rise) begin
            for (int j = 0; j < NC; j++) m_crun[j] = cpu_en[j] && !(cpu_stoppable[j] && req);
            void'(cp.pop_front()); cp.push_back(cact);
         end
         m_csq = cpu_src;
      end
   end

   // per-cycle comparison, pulse-width and edge monitors
   int hw[NB];
   int brise[NB], crise[NC];
   bit [NB-1:0] pb;
   bit [NC-1:0] pt;
   always @(negedge clk) begin
      if (rst_n && cyc > 0) begin
         logic [NB-1:0] eb;
         logic [NC-1:0] et, ec, ed;
         for (int i = 0; i < NB; i++) eb[i] = m_bsq[i] & m_brun[i];
         for (int j = 0; j < NC; j++) begin
            ed[j] = m_crun[j];
            et[j] = m_crun[j] ? m_csq : 1'b1;
            ec[j] = m_crun[j] ? !m_csq : 1'b0;
         end
         check(bus_clk == eb, "R2 R3 R4 R5 R6 bus model", int'(bus_clk), int'(eb));
         check({cpu_t, cpu_c, cpu_c_drv} == {et, ec, ed}, "R7 R8 R9 R10 R11 cpu model",
               int'({cpu_t, cpu_c, cpu_c_drv}), int'({et, ec, ed}));
         for (int i = 0; i < NB; i++) begin
            if (bus_clk[i]) hw[i]++;
            else if (hw[i] != 0) begin
               check(hw[i] == 4, "R5 high pulse width", hw[i], 4);
               hw[i] = 0;
            end
            if (bus_clk[i] && !pb[i]) brise[i]++;
         end
         for (int j = 0; j < NC; j++) if (cpu_t[j] && !pt[j]) crise[j]++;
      end
      pb = bus_clk;
      pt = cpu_t;
   end

   always @(posedge clk) if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_counts();
      for (int i = 0; i < NB; i++) brise[i] = 0;
      for (int j = 0; j < NC; j++) crise[j] = 0;
   endtask

   int seed = 7;
   function automatic int rnd(input int m);
      seed = seed * 1103515245 + 12345;
      return ((seed >>> 8) & 32'h7fff) % m;
   endfunction

   initial begin
      wait_cyc(5);
      check(bus_clk == '0, "R1 bus reset", int'(bus_clk), 0);
      check(cpu_t == '1 && cpu_c == '0 && cpu_c_drv == '0, "R1 cpu reset",
            int'({cpu_t, cpu_c, cpu_c_drv}), int'({3'b111, 3'b000, 3'b000}));
      rst_n = 1'b1;
      wait_cyc(40);
      check(cpu_c_drv == '1, "R11 pairs running", int'(cpu_c_drv), 7);

      // bus stop
      bus_stop_n = 1'b0;
      wait_cyc(14);
      clear_counts();
      wait_cyc(32);
      for (int i = 0; i < NB; i++)
         if (bus_stoppable[i]) check(brise[i] == 0 && bus_clk[i] == 0, "R3 stopped low", brise[i], 0);
         else check(brise[i] == 4, "R4 free runs", brise[i], 4);
      bus_stop_n = 1'b1;
      clear_counts();
      wait_cyc(24);
      for (int i = 3; i < NB; i++) check(brise[i] >= 2, "R5 restart", brise[i], 2);

      // processor stop
      cpu_stop_n = 1'b0;
      wait_cyc(20);
      clear_counts();
      wait_cyc(20);
      check(crise[0] == 5, "R9 free pair runs", crise[0], 5);
      check(cpu_t[2:1] == 2'b11 && cpu_c[2:1] == 0 && cpu_c_drv[2:1] == 0, "R8 parked levels",
            int'({cpu_t[2:1], cpu_c[2:1], cpu_c_drv[2:1]}), int'(6'b110000));
      cpu_stop_n = 1'b1;
      wait_cyc(24);
      check(cpu_c_drv == '1 && (cpu_c ^ cpu_t) == '1, "R11 running complement",
            int'({cpu_c_drv, cpu_c ^ cpu_t}), int'(6'b111111));

      // disables
      bus_en[5] = 1'b0; cpu_en[0] = 1'b0;
      wait_cyc(12);
      clear_counts();
      wait_cyc(32);
      check(brise[5] == 0 && bus_clk[5] == 0, "R6 disabled bus low", brise[5], 0);
      check(cpu_t[0] && !cpu_c[0] && !cpu_c_drv[0], "R10 disabled pair parked",
            int'({cpu_t[0], cpu_c[0], cpu_c_drv[0]}), 4);
      bus_en[5] = 1'b1; cpu_en[0] = 1'b1;

      // random stop pulses of every length and phase
      for (int k = 0; k < 400; k++) begin
         if (rnd(2) == 1) bus_stop_n = ~bus_stop_n;
         if (rnd(2) == 1) cpu_stop_n = ~cpu_stop_n;
         if (rnd(16) == 0) bus_stoppable = NB'(rnd(1024));
         if (rnd(16) == 0) cpu_stoppable = NC'(rnd(8));
         if (rnd(20) == 0) bus_en[rnd(NB)] = rnd(2) == 1;
         if (rnd(20) == 0) cpu_en[rnd(NC)] = rnd(2) == 1;
         wait_cyc(1 + rnd(12));
      end
      wait_cyc(20);
      finish_run();
   end
endmodule